// File: doc/BRIEF.md
# Pushbutton Debouncer with Single-Pulse Output

This block turns a raw mechanical pushbutton signal into clean control for a
fast synchronous design. The button input comes in with no timing relation to
the system clock and may chatter for several milliseconds on each make and
break. The block first brings the signal into the clock domain with a flop
chain. It then passes on the first change it sees at once and shuts out every
later change until a lockout counter has run its full span. A held level
output shows the cleaned button state. A one-cycle pulse marks each accepted
press, and nothing is pulsed on release.

The pulse is meant to drive the clock enable of a downstream counter, so one
press of the button moves that counter by exactly one. The lockout span is
2^CNT_W clocks. The default CNT_W of 17 gives about 5.5 ms at a 24 MHz
system clock. Bounce time differs between switches and grows as they wear, so
the span is a parameter. If SAMPLE_DIV is set above 1, a low-rate sampling
stage sits between the synchronizer and the lockout. It takes a new sample
only once every SAMPLE_DIV clocks, which adds protection when a switch still
gives double pulses.

Top module: `button_pulse_debouncer`

## Requirements
- R1: The raw button input passes through a synchronizer of SYNC_STAGES flops (default 2) before any other logic. With SAMPLE_DIV = 1 and the block idle, a rise of `btn_raw` set up before a clock edge shows on `btn_level` after the third clock edge.
- R2: With the lockout idle, the block accepts a change of the synchronized input at the next clock edge. It does not wait for the input to settle, and each accepted change starts the lockout.
- R3: After an accepted change, `btn_level` holds for 2^CNT_W clock cycles and ignores every input change in that span. A difference that is still present when the span ends is accepted at the next edge.
- R4: A release (a change to 0, where 1 means pressed) also starts the lockout, so bounce on release cannot produce a press. No pulse is ever produced for a release.
- R5: `press_pulse` is high for exactly one clock cycle for each accepted press. It is decoded from a two-flop shift register of the cleaned level as newer stage = 1 and older stage = 0, and it appears two clock edges after `btn_level` rises.
- R6: `btn_level` is a registered output that gives the debounced button state: 1 means pressed, 0 means released.
- R7: A synchronous active-high `rst` clears the synchronizer, the lockout counter and the shift register to the released state. While `rst` is high both outputs are 0, and with the button released no pulse appears after reset ends.
- R8: With SAMPLE_DIV > 1, the synchronized input is sampled once every SAMPLE_DIV clocks and held in between, so `btn_level` rises 4 to 3+SAMPLE_DIV edges after a clean press.
- R9: A press whose bounce dies out within the lockout span gives exactly one pulse, so a counter enabled by `press_pulse` advances by exactly one.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| btn_raw | input | 1 | Raw button contact, asynchronous, 1 = pressed |
| press_pulse | output | 1 | One-cycle pulse for each accepted press |
| btn_level | output | 1 | Debounced button level, registered |

## Verification
The bench drives bursts of chatter on both press and release and checks three
things: one pulse per press, no pulse for a release, and no change of the
cleaned level during lockout. A design that ignored lockout on release, or
that restarted the count on every bounce, would give extra or missing counts
here. It also checks the lockout boundary with a release placed just after the
span ends and a re-press during the following span. A window that is one cycle
short or long would shift the level edges and upset the pulse total. The
sampled variant and the fixed latency of the plain path are checked too, since
a missing synchronizer stage or a wrong sampling phase would move the level
edge outside its allowed cycle.

// File: rtl/dbnc_pkg.sv
package dbnc_pkg;

  // Lockout window state
  typedef enum logic [0:0] {
    WIN_OPEN   = 1'b0,
    WIN_LOCKED = 1'b1
  } win_state_e;

  // Button level meaning released; all stages reset to this
  localparam logic BTN_IDLE = 1'b0;

endpackage

// File: rtl/dbnc_sync.sv
module dbnc_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic din,
  output logic dout
);
  import dbnc_pkg::*;

  logic [STAGES-1:0] chain_q;

  for (genvar i = 0; i < STAGES; i++) begin : g_stage
    if (i == 0) begin : g_first
      always_ff @(posedge clk) begin
        if (rst) chain_q[0] <= BTN_IDLE;
        else     chain_q[0] <= din;
      end
    end else begin : g_next
      always_ff @(posedge clk) begin
        if (rst) chain_q[i] <= BTN_IDLE;
        else     chain_q[i] <= chain_q[i-1];
      end
    end
  end

  assign dout = chain_q[STAGES-1];

  AST_SYNC_DELAY: assert property (@(posedge clk) disable iff (rst)
    $stable(din) && $stable(chain_q) |=> $stable(dout)); // R1

endmodule

// File: rtl/dbnc_sampler.sv
module dbnc_sampler #(
  parameter int DIV = 1
) (
  input  logic clk,
  input  logic rst,
  input  logic din,
  output logic dout
);
  import dbnc_pkg::*;

  if (DIV <= 1) begin : g_bypass
    logic unused_bypass;
    assign unused_bypass = ^{clk, rst};
    assign dout = din;
  end else begin : g_div
    localparam int DW = $clog2(DIV);
    localparam logic [DW-1:0] LAST = DW'(DIV - 1);

    logic [DW-1:0] div_q;
    logic          smp_q;
    logic          tick;

    assign tick = (div_q == LAST);

    always_ff @(posedge clk) begin
      if (rst) begin
        div_q <= '0;
        smp_q <= BTN_IDLE;
      end else if (tick) begin
        div_q <= '0;
        smp_q <= din;
      end else begin
        div_q <= div_q + 1'b1;
      end
    end

    assign dout = smp_q;

    AST_SAMPLE_ONLY_ON_TICK: assert property (@(posedge clk) disable iff (rst)
      !tick |=> $stable(smp_q)); // R8
    AST_DIV_IN_RANGE: assert property (@(posedge clk) disable iff (rst)
      div_q <= LAST); // R8
  end

endmodule

// File: rtl/dbnc_lockout.sv
module dbnc_lockout #(
  parameter int CNT_W = 17
) (
  input  logic clk,
  input  logic rst,
  input  logic din,
  output logic level_o
);
  import dbnc_pkg::*;

  localparam logic [CNT_W-1:0] TERM = '1;

  win_state_e       st_q;
  logic [CNT_W-1:0] cnt_q;
  logic             busy;

  assign busy = (st_q == WIN_LOCKED);

  always_ff @(posedge clk) begin
    if (rst) begin
      st_q    <= WIN_OPEN;
      cnt_q   <= '0;
      level_o <= BTN_IDLE;
    end else begin
      unique case (st_q)
        WIN_OPEN: begin
          if (din != level_o) begin
            level_o <= din;
            st_q    <= WIN_LOCKED;
            cnt_q   <= '0;
          end
        end
        WIN_LOCKED: begin
          if (cnt_q == TERM) begin
            st_q  <= WIN_OPEN;
            cnt_q <= '0;
          end else begin
            cnt_q <= cnt_q + 1'b1;
          end
        end
        default: st_q <= WIN_OPEN;
      endcase
    end
  end

  AST_ACCEPT_AT_ONCE: assert property (@(posedge clk) disable iff (rst)
    (!busy && din != level_o) |=> !$stable(level_o)); // R2
  AST_CHANGE_STARTS_LOCK: assert property (@(posedge clk) disable iff (rst)
    !$stable(level_o) |-> (busy && cnt_q == '0)); // R4
  AST_LOCK_HOLDS_LEVEL: assert property (@(posedge clk) disable iff (rst)
    busy |=> $stable(level_o)); // R3
  AST_OPEN_COUNT_CLEAR: assert property (@(posedge clk) disable iff (rst)
    (busy && cnt_q == TERM) |=> (!busy && cnt_q == '0)); // R3

endmodule

// File: rtl/dbnc_edge.sv
module dbnc_edge (
  input  logic clk,
  input  logic rst,
  input  logic level_i,
  output logic pulse_o
);
  import dbnc_pkg::*;

  localparam int HIST = 2;

  // hist_q[0] is the newer stage, hist_q[HIST-1] the older
  logic [HIST-1:0] hist_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      hist_q  <= {HIST{BTN_IDLE}};
      pulse_o <= 1'b0;
    end else begin
      hist_q  <= {hist_q[HIST-2:0], level_i};
      pulse_o <= hist_q[0] & ~hist_q[HIST-1];
    end
  end

  AST_PULSE_SINGLE: assert property (@(posedge clk) disable iff (rst)
    pulse_o |=> !pulse_o); // R5
  AST_NO_PULSE_ON_RELEASE: assert property (@(posedge clk) disable iff (rst)
    $fell(level_i) |=> ##1 !pulse_o); // R4

endmodule

// File: rtl/button_pulse_debouncer.sv
module button_pulse_debouncer #(
  parameter int CNT_W       = 17,
  parameter int SAMPLE_DIV  = 1,
  parameter int SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic btn_raw,
  output logic press_pulse,
  output logic btn_level
);

  logic sync_lvl;
  logic smp_lvl;

  dbnc_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk (clk),
    .rst (rst),
    .din (btn_raw),
    .dout(sync_lvl)
  );

  dbnc_sampler #(.DIV(SAMPLE_DIV)) u_sampler (
    .clk (clk),
    .rst (rst),
    .din (sync_lvl),
    .dout(smp_lvl)
  );

  dbnc_lockout #(.CNT_W(CNT_W)) u_lockout (
    .clk    (clk),
    .rst    (rst),
    .din    (smp_lvl),
    .level_o(btn_level)
  );

  dbnc_edge u_edge (
    .clk    (clk),
    .rst    (rst),
    .level_i(btn_level),
    .pulse_o(press_pulse)
  );

  AST_PULSE_WHILE_PRESSED: assert property (@(posedge clk) disable iff (rst)
    press_pulse |-> btn_level); // R5

endmodule

// File: tb/button_pulse_debouncer_tb.sv
`timescale 1ns/1ps

module dbnc_ref_model #(
  parameter int W   = 4,
  parameter int DIV = 1
) (
  input  logic clk,
  input  logic rst,
  input  logic raw,
  output bit   m_lvl,
  output bit   m_pulse
);
  bit s1, s2, smp, d_new, d_old;
  int phase, left;

  always @(posedge clk) begin
    bit fin;
    bit np;
    if (rst) begin
      s1 = 0; s2 = 0; smp = 0; d_new = 0; d_old = 0;
      phase = 0; left = 0; m_lvl = 0; m_pulse = 0;
    end else begin
      fin   = (DIV > 1) ? smp : s2;
      np    = d_new && !d_old;
      d_old = d_new;
      d_new = m_lvl;
      if (DIV > 1) begin
        if (phase == DIV - 1) begin smp = s2; phase = 0; end
        else phase = phase + 1;
      end
      s2 = s1;
      s1 = raw;
      if (left == 0 && fin != m_lvl) begin
        m_lvl = fin;
        left  = 1 << W;
      end else if (left > 0) begin
        left = left - 1;
      end
      m_pulse = np;
    end
  end
endmodule

module button_pulse_debouncer_tb;
  localparam int CW  = 4;
  localparam int DIV = 4;

  logic clk = 0;
  logic rst = 1;
  logic raw = 0;
  logic pulse_a, level_a, pulse_b, level_b;
  bit   mp_a, ml_a, mp_b, ml_b;

  int total = 0;
  int bad   = 0;
  int cnt_a = 0;
  int cnt_b = 0;
  bit cmp_on = 0;

  always #2 clk = ~clk;

  button_pulse_debouncer #(.CNT_W(CW), .SAMPLE_DIV(1)) u_dut (
    .clk(clk), .rst(rst), .btn_raw(raw),
    .press_pulse(pulse_a), .btn_level(level_a));

  button_pulse_debouncer #(.CNT_W(CW), .SAMPLE_DIV(DIV)) u_dut_smp (
    .clk(clk), .rst(rst), .btn_raw(raw),
    .press_pulse(pulse_b), .btn_level(level_b));

  dbnc_ref_model #(.W(CW), .DIV(1)) u_ref_a (
    .clk(clk), .rst(rst), .raw(raw), .m_lvl(ml_a), .m_pulse(mp_a));
  dbnc_ref_model #(.W(CW), .DIV(DIV)) u_ref_b (
    .clk(clk), .rst(rst), .raw(raw), .m_lvl(ml_b), .m_pulse(mp_b));

  task automatic check(input string req, input int act, input int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", req, act, exp, $time);
    end
  endtask

  task automatic summary();
    $display("  test done: total=%0d bad=%0d", total, bad);
  endtask

  // Per-cycle comparison with the reference model (R6 level, R5 pulse, R8 sampled)
  always @(negedge clk) begin
    if (!rst) begin
      if (pulse_a) cnt_a++;
      if (pulse_b) cnt_b++;
    end
    if (cmp_on && !rst) begin
      check("R6 level", int'(level_a), int'(ml_a));
      check("R5 pulse", int'(pulse_a), int'(mp_a));
      check("R8 sampled level", int'(level_b), int'(ml_b));
      check("R8 sampled pulse", int'(pulse_b), int'(mp_b));
    end
  end

  task automatic hold(input logic v, input int n);
    raw = v;
    repeat (n) @(negedge clk);
  endtask

  task automatic burst(input logic [15:0] pat, input int len);
    for (int i = len - 1; i >= 0; i--) hold(pat[i], 1);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    bad++;
    $display("FAIL watchdog actual=timeout expected=finish");
    summary();
    $finish;
  end

  initial begin
    int ka, kb, c0a, c0b;
    // R7: outputs quiet in reset
    repeat (4) @(negedge clk);
    check("R7 reset level", int'(level_a), 0);
    check("R7 reset pulse", int'(pulse_a), 0);
    rst = 0;
    cmp_on = 1;
    repeat (20) @(negedge clk);
    check("R7 no pulse after reset", cnt_a + cnt_b, 0);

    // R1/R2/R8: clean press latency
    ka = 0; kb = 0;
    raw = 1;
    for (int k = 1; k <= 20; k++) begin
      @(negedge clk);
      if (ka == 0 && level_a) ka = k;
      if (kb == 0 && level_b) kb = k;
    end
    check("R1 level latency", ka, 3);
    check("R8 sampled latency in range", int'(kb >= 4 && kb <= 3 + DIV), 1);
    hold(1, 30);
    check("R5 one pulse per clean press", cnt_a, 1);
    check("R8 one pulse sampled", cnt_b, 1);
    hold(0, 40);
    check("R4 no pulse on clean release", cnt_a, 1);
    check("R6 level released", int'(level_a), 0);

    // R9: bouncy press, R4: bouncy release
    c0a = cnt_a; c0b = cnt_b;
    burst(16'b1011010011, 10);
    hold(1, 40);
    check("R9 bouncy press one pulse", cnt_a - c0a, 1);
    check("R9 bouncy press one pulse sampled", cnt_b - c0b, 1);
    c0a = cnt_a; c0b = cnt_b;
    burst(16'b0100101101, 10);
    hold(0, 40);
    check("R4 bouncy release no pulse", cnt_a - c0a, 0);
    check("R4 bouncy release no pulse sampled", cnt_b - c0b, 0);

    // R3: glitch inside lockout does not move level
    c0a = cnt_a;
    raw = 1;
    while (!level_a) @(negedge clk);
    hold(1, 2);
    hold(0, 2);
    raw = 1;
    for (int k = 0; k < 10; k++) begin
      @(negedge clk);
      check("R3 level held in lockout", int'(level_a), 1);
    end
    hold(1, 30);
    check("R3 glitch adds no pulse", cnt_a - c0a, 1);
    hold(0, 40);

    // R3: short drop after window ends is accepted, re-press after next window
    c0a = cnt_a;
    hold(1, 30);
    hold(0, 2);
    hold(1, 60);
    check("R3 change after window accepted", cnt_a - c0a, 2);
    hold(0, 40);
    check("R6 final level released", int'(level_a), 0);

    summary();
    $finish;
  end
endmodule